// File: doc/BRIEF.md
# Paced Parallel ADC Conversion Sequencer

This block drives an 8-bit successive-approximation converter that has a parallel output bus. It pulses an active-low start strobe to begin a conversion. It then waits for the converter's active-low end-of-conversion interrupt and holds off for a guaranteed minimum number of clocks, so that the converter can clear its interrupt. After that it pulses an active-low read strobe and captures the data bus into an output register. All of its logic runs on one fast system clock.

Conversions are not timed by a derived slow clock. An internal divider makes a single-cycle pacing pulse every `TICK_DIV` system clocks, for example 5 samples per second. Each pulse that finds the sequencer idle starts one conversion. The sequencer then returns to idle and waits for the next pulse, so the captured sample keeps refreshing with no reset needed. The interrupt input is asynchronous to the system clock and is brought in through a two-stage synchronizer.

Top module: `adc_sample_ctrl`

## Requirements
- R1: While `rst_n` is low and on the first cycle after it is released, `adc_wr_n` and `adc_rd_n` are high (1), `sample_o` is all zeros and `sample_new_o` is low.
- R2: The pacing pulse repeats every `TICK_DIV` clocks. A pulse that finds the sequencer idle makes `adc_wr_n` fall on the next rising edge, so starts of back-to-back conversions lie exactly `TICK_DIV` clocks apart.
- R3: `adc_wr_n` stays low for exactly `WR_W` clock cycles per conversion, and it is high for the rest of the conversion.
- R4: After the start strobe, the sequencer waits for as long as `adc_int_n` stays high. No read strobe occurs before the interrupt has been seen low.
- R5: `adc_rd_n` falls on the rising edge that comes `MIN_GAP` clock periods after the first rising edge that samples `adc_int_n` low. `MIN_GAP` must be at least 3.
- R6: `adc_rd_n` stays low for exactly 2 clock cycles. `adc_rd_n` and `adc_wr_n` are never low at the same time.
- R7: `sample_o` takes the value on `adc_data` at the rising edge where `adc_rd_n` returns high. `sample_new_o` is high for exactly that one cycle. `sample_o` changes at no other time except reset.
- R8: A pacing pulse that arrives while a conversion is in progress is dropped. The next conversion starts on the first pulse after the sequencer is idle again, which is 2·`TICK_DIV` after the previous start when one pulse was dropped.
- R9: Conversions repeat without a reset. Each start strobe yields exactly one `sample_new_o` pulse, including after a reset applied in the middle of a conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| adc_int_n | input | 1 | Converter end-of-conversion interrupt, active low, asynchronous |
| adc_data | input | DATA_W | Converter parallel data bus |
| adc_wr_n | output | 1 | Start-conversion strobe to the converter, active low |
| adc_rd_n | output | 1 | Read strobe to the converter, active low |
| sample_o | output | DATA_W | Most recently captured sample |
| sample_new_o | output | 1 | One-cycle pulse when `sample_o` is refreshed |

## Verification
A behavioural converter model in the bench answers each start strobe after a latency taken from a table. The table also sets the value on the data bus, with latencies from zero up to most of a sampling period and with data words of all-zeros, all-ones, alternating bits and single set bits at either end. The mixed latencies show whether the read delay is counted from the interrupt, as required, and not from the start strobe; every case must give the same interrupt-to-read spacing. The varied data words catch a lost, reordered or stale bit in the capture. A conversion longer than one period checks that a pacing pulse is dropped rather than queued. A reset in the middle of a conversion checks that sampling resumes on its own.

// File: rtl/adc_ctrl_pkg.sv
package adc_ctrl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_START = 3'd1,
        ST_CONV  = 3'd2,
        ST_WAIT  = 3'd3,
        ST_READ1 = 3'd4,
        ST_READ2 = 3'd5
    } conv_state_e;

    // Read pulse length in clocks (READ1 + READ2)
    localparam int unsigned RD_PULSE = 2;

    function automatic int unsigned max2(int unsigned a, int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/adc_rate_tick.sv
module adc_rate_tick #(
    parameter int unsigned DIV = 25_000_000
) (
    input  logic clk_i,
    input  logic rst_ni,
    output logic tick_o
);
    localparam int unsigned CW = (DIV > 2) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          tick;
    } tick_regs_t;

    tick_regs_t t_d, t_q;

    always_comb begin
        t_d      = t_q;
        t_d.tick = 1'b0;
        if (t_q.cnt == LAST) begin
            t_d.cnt  = '0;
            t_d.tick = 1'b1;
        end else begin
            t_d.cnt = t_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            t_q <= '0;
        end else begin
            t_q <= t_d;
        end
    end

    assign tick_o = t_q.tick;

    AST_TICK_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        t_q.tick |=> !t_q.tick); // R2

endmodule

// File: rtl/adc_int_sync.sv
module adc_int_sync #(
    parameter int unsigned STAGES  = 2,
    parameter logic        IDLE_LV = 1'b1
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic async_i,
    output logic sync_o
);
    logic [STAGES-1:0] chain_d, chain_q;

    generate
        if (STAGES == 1) begin : g_single
            always_comb chain_d = async_i;
        end else begin : g_multi
            always_comb chain_d = {chain_q[STAGES-2:0], async_i};
        end
    endgenerate

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            chain_q <= {STAGES{IDLE_LV}};
        end else begin
            chain_q <= chain_d;
        end
    end

    assign sync_o = chain_q[STAGES-1];

endmodule

// File: rtl/adc_conv_fsm.sv
module adc_conv_fsm
    import adc_ctrl_pkg::*;
#(
    parameter int unsigned DATA_W    = 8,
    parameter int unsigned WR_W      = 2,
    parameter int unsigned MIN_GAP   = 8,
    parameter int unsigned SYNC_LAT  = 2
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              tick_i,
    input  logic              int_s_i,
    input  logic [DATA_W-1:0] data_i,
    output logic              wr_n_o,
    output logic              rd_n_o,
    output logic [DATA_W-1:0] smp_o,
    output logic              smp_new_o
);
    // Cycles spent in WAIT so that the read strobe lands MIN_GAP clocks
    // after the pin-level interrupt was first sampled (sync latency included).
    localparam int unsigned WAIT_LEN = (MIN_GAP > SYNC_LAT + 1) ? (MIN_GAP - SYNC_LAT) : 1;
    localparam int unsigned CNT_MAX  = max2(WR_W, WAIT_LEN);
    localparam int unsigned CNT_W    = (CNT_MAX > 1) ? $clog2(CNT_MAX + 1) : 1;
    localparam logic [CNT_W-1:0] WR_LAST   = CNT_W'(WR_W - 1);
    localparam logic [CNT_W-1:0] WAIT_LAST = CNT_W'(WAIT_LEN - 1);

    typedef struct packed {
        conv_state_e       state;
        logic [CNT_W-1:0]  cnt;
        logic              wr_n;
        logic              rd_n;
        logic [DATA_W-1:0] smp;
        logic              smp_new;
    } seq_regs_t;

    localparam seq_regs_t RESET_VAL = '{
        state:   ST_IDLE,
        cnt:     '0,
        wr_n:    1'b1,
        rd_n:    1'b1,
        smp:     '0,
        smp_new: 1'b0
    };

    seq_regs_t r_d, r_q;

    always_comb begin
        r_d         = r_q;
        r_d.smp_new = 1'b0;
        unique case (r_q.state)
            ST_IDLE: begin
                r_d.wr_n = 1'b1;
                r_d.rd_n = 1'b1;
                if (tick_i) begin
                    r_d.state = ST_START;
                    r_d.cnt   = '0;
                    r_d.wr_n  = 1'b0;
                end
            end
            ST_START: begin
                r_d.rd_n = 1'b1;
                if (r_q.cnt == WR_LAST) begin
                    r_d.state = ST_CONV;
                    r_d.wr_n  = 1'b1;
                    r_d.cnt   = '0;
                end else begin
                    r_d.wr_n = 1'b0;
                    r_d.cnt  = r_q.cnt + 1'b1;
                end
            end
            ST_CONV: begin
                r_d.wr_n = 1'b1;
                r_d.rd_n = 1'b1;
                if (!int_s_i) begin
                    r_d.state = ST_WAIT;
                    r_d.cnt   = '0;
                end
            end
            ST_WAIT: begin
                r_d.wr_n = 1'b1;
                if (r_q.cnt == WAIT_LAST) begin
                    r_d.state = ST_READ1;
                    r_d.rd_n  = 1'b0;
                    r_d.cnt   = '0;
                end else begin
                    r_d.rd_n = 1'b1;
                    r_d.cnt  = r_q.cnt + 1'b1;
                end
            end
            ST_READ1: begin
                r_d.wr_n  = 1'b1;
                r_d.rd_n  = 1'b0;
                r_d.state = ST_READ2;
            end
            ST_READ2: begin
                r_d.wr_n    = 1'b1;
                r_d.rd_n    = 1'b1;
                r_d.smp     = data_i;
                r_d.smp_new = 1'b1;
                r_d.state   = ST_IDLE;
            end
            default: begin
                r_d = RESET_VAL;
            end
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            r_q <= RESET_VAL;
        end else begin
            r_q <= r_d;
        end
    end

    assign wr_n_o    = r_q.wr_n;
    assign rd_n_o    = r_q.rd_n;
    assign smp_o     = r_q.smp;
    assign smp_new_o = r_q.smp_new;

    AST_WR_FROM_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(r_q.wr_n) |-> $past(tick_i)); // R2

    AST_CONV_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (r_q.state == ST_CONV && int_s_i) |=> (r_q.state == ST_CONV && r_q.rd_n)); // R4

    AST_RD_AFTER_WAIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(r_q.rd_n) |-> ($past(r_q.state) == ST_WAIT)); // R5

    AST_STROBE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(!r_q.wr_n && !r_q.rd_n)); // R6

    AST_LOAD_ON_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(r_q.smp) |-> $past(r_q.state == ST_READ2)); // R7

    AST_NEW_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        r_q.smp_new |=> !r_q.smp_new); // R7

    AST_TICK_DROPPED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tick_i && (r_q.state == ST_CONV || r_q.state == ST_WAIT ||
                    r_q.state == ST_READ1 || r_q.state == ST_READ2)) |=> r_q.wr_n); // R8

endmodule

// File: rtl/adc_sample_ctrl.sv
module adc_sample_ctrl #(
    parameter int unsigned DATA_W   = 8,
    parameter int unsigned TICK_DIV = 25_000_000,
    parameter int unsigned WR_W     = 2,
    parameter int unsigned MIN_GAP  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              adc_int_n,
    input  logic [DATA_W-1:0] adc_data,
    output logic              adc_wr_n,
    output logic              adc_rd_n,
    output logic [DATA_W-1:0] sample_o,
    output logic              sample_new_o
);
    localparam int unsigned SYNC_STAGES = 2;

    logic tick;
    logic int_s;

    adc_rate_tick #(
        .DIV (TICK_DIV)
    ) i_rate (
        .clk_i  (clk),
        .rst_ni (rst_n),
        .tick_o (tick)
    );

    adc_int_sync #(
        .STAGES  (SYNC_STAGES),
        .IDLE_LV (1'b1)
    ) i_sync (
        .clk_i   (clk),
        .rst_ni  (rst_n),
        .async_i (adc_int_n),
        .sync_o  (int_s)
    );

    adc_conv_fsm #(
        .DATA_W   (DATA_W),
        .WR_W     (WR_W),
        .MIN_GAP  (MIN_GAP),
        .SYNC_LAT (SYNC_STAGES)
    ) i_fsm (
        .clk_i     (clk),
        .rst_ni    (rst_n),
        .tick_i    (tick),
        .int_s_i   (int_s),
        .data_i    (adc_data),
        .wr_n_o    (adc_wr_n),
        .rd_n_o    (adc_rd_n),
        .smp_o     (sample_o),
        .smp_new_o (sample_new_o)
    );

    AST_NEW_WITH_RD_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        sample_new_o |-> (adc_rd_n && !$past(adc_rd_n))); // R7

endmodule

// File: tb/test_adc_sample_ctrl.sv
module test_adc_sample_ctrl;
    localparam int DW   = 8;
    localparam int DIV  = 60;
    localparam int WRW  = 2;
    localparam int GAP  = 8;
    localparam int NVEC = 6;

    localparam logic [DW-1:0] VEC_DATA [NVEC] = '{8'h00, 8'hFF, 8'h5A, 8'h81, 8'h01, 8'h80};
    localparam int            VEC_LAT  [NVEC] = '{0, 1, 7, 30, 12, 2};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic adc_int_n = 1'b1;
    logic [DW-1:0] adc_data = '0;
    logic adc_wr_n, adc_rd_n, sample_new_o;
    logic [DW-1:0] sample_o;

    always #4 clk = ~clk;

    adc_sample_ctrl #(
        .DATA_W (DW), .TICK_DIV (DIV), .WR_W (WRW), .MIN_GAP (GAP)
    ) i_adc_sample_ctrl (
        .clk (clk), .rst_n (rst_n), .adc_int_n (adc_int_n), .adc_data (adc_data),
        .adc_wr_n (adc_wr_n), .adc_rd_n (adc_rd_n),
        .sample_o (sample_o), .sample_new_o (sample_new_o)
    );

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int checks = 0;
    int errors = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // converter model and monitors
    int conv_lat = 0;
    bit conv_busy = 0;
    int conv_cnt = 0;
    int t_int = 0;
    bit int_seen = 0;
    logic prev_wr = 1'b1, prev_rd = 1'b1;
    logic [DW-1:0] prev_smp = '0;
    int wr_len = 0, rd_len = 0;
    int wr_fall_last = 0, wr_fall_prev = 0;
    int n_wr = 0, n_smp = 0;
    logic [DW-1:0] last_smp = '0;

    always @(negedge clk) begin
        if (!rst_n) begin
            prev_wr = 1'b1; prev_rd = 1'b1; prev_smp = '0;
            conv_busy = 0; int_seen = 0; adc_int_n = 1'b1;
            wr_len = 0; rd_len = 0;
        end else begin
            // start strobe width R3
            if (!adc_wr_n) begin
                if (prev_wr) begin
                    wr_fall_prev = wr_fall_last;
                    wr_fall_last = cyc;
                    n_wr++;
                    wr_len = 0;
                end
                wr_len++;
            end else if (!prev_wr) begin
                chk(wr_len == WRW, "R3 wr_n low width", wr_len, WRW);
            end
            // read strobe R4 R5 R6
            if (!adc_rd_n) begin
                if (prev_rd) begin
                    chk(int_seen, "R4 read before interrupt", int_seen, 1);
                    chk(cyc - t_int == GAP + 1, "R5 interrupt-to-read spacing", cyc - t_int, GAP + 1);
                    chk(adc_wr_n == 1'b1, "R6 strobes overlap", adc_wr_n, 1);
                    int_seen = 0;
                    rd_len = 0;
                end
                rd_len++;
            end else if (!prev_rd) begin
                chk(rd_len == 2, "R6 rd_n low width", rd_len, 2);
            end
            // capture R7
            if (sample_new_o) begin
                n_smp++;
                last_smp = sample_o;
                chk(adc_rd_n && !prev_rd, "R7 capture not at read end", adc_rd_n, 1);
            end else if (sample_o !== prev_smp) begin
                chk(0, "R7 sample changed without pulse", sample_o, prev_smp);
            end
            prev_smp = sample_o;
            // model
            if (!adc_wr_n) begin
                adc_int_n = 1'b1; conv_busy = 1; conv_cnt = 0;
            end else if (conv_busy) begin
                conv_cnt++;
                if (conv_cnt >= conv_lat) begin
                    adc_int_n = 1'b0; conv_busy = 0; t_int = cyc; int_seen = 1;
                end
            end
            if (!adc_rd_n) adc_int_n = 1'b1;
            prev_wr = adc_wr_n;
            prev_rd = adc_rd_n;
        end
    end

    task automatic wait_smp(input string req);
        int start;
        int t;
        start = n_smp;
        t = 0;
        while (n_smp == start && t < 3000) begin
            @(posedge clk);
            t++;
        end
        if (n_smp == start) chk(0, req, 0, 1);
        @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        chk(adc_wr_n == 1'b1, "R1 wr_n in reset", adc_wr_n, 1);
        chk(adc_rd_n == 1'b1, "R1 rd_n in reset", adc_rd_n, 1);
        rst_n = 1'b1;
        @(negedge clk);
        chk(sample_o == '0, "R1 sample after reset", sample_o, 0);
        chk(sample_new_o == 1'b0, "R1 pulse after reset", sample_new_o, 0);
        chk(adc_wr_n && adc_rd_n, "R1 strobes after reset", {adc_wr_n, adc_rd_n}, 3);

        // table walk: R2 R7 R9
        for (int i = 0; i < NVEC; i++) begin
            adc_data = VEC_DATA[i];
            conv_lat = VEC_LAT[i];
            wait_smp("R9 sample missing");
            chk(last_smp == VEC_DATA[i], "R7 captured data", last_smp, VEC_DATA[i]);
            if (i > 0)
                chk(wr_fall_last - wr_fall_prev == DIV, "R2 start spacing", wr_fall_last - wr_fall_prev, DIV);
        end
        chk(n_smp == NVEC, "R9 samples per run", n_smp, NVEC);
        chk(n_smp == n_wr, "R9 one sample per start", n_smp, n_wr);

        // R8 R4: conversion longer than a period
        adc_data = 8'hA5;
        conv_lat = DIV + 10;
        wait_smp("R4 long conversion never read");
        chk(last_smp == 8'hA5, "R7 captured data long", last_smp, 8'hA5);
        adc_data = 8'h3C;
        conv_lat = 4;
        wait_smp("R8 sample missing");
        chk(wr_fall_last - wr_fall_prev == 2 * DIV, "R8 pulse dropped", wr_fall_last - wr_fall_prev, 2 * DIV);
        chk(last_smp == 8'h3C, "R7 captured data after drop", last_smp, 8'h3C);

        // reset mid-conversion: R1 R9
        conv_lat = 20;
        while (adc_wr_n) @(negedge clk);
        repeat (5) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk(sample_o == '0, "R1 sample cleared", sample_o, 0);
        chk(adc_wr_n && adc_rd_n && !sample_new_o, "R1 outputs idle", {adc_wr_n, adc_rd_n, sample_new_o}, 6);
        rst_n = 1'b1;
        adc_data = 8'hC3;
        conv_lat = 5;
        begin
            int base;
            base = n_wr;
            wait_smp("R9 no resume after reset");
            chk(n_wr == base + 1, "R9 one start after reset", n_wr, base + 1);
        end
        chk(last_smp == 8'hC3, "R9 data after reset", last_smp, 8'hC3);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule